// File: doc/BRIEF.md
# Bridge Parity Error Reporting Unit

This unit sits beside the two bus engines of a two-port PCI-to-PCI bridge. It decides when a data parity problem turns into the secondary-side master data parity status bit, and when it turns into a drive of the primary PERR# line. For every completed data phase, the bus engines give it the phase's context: transfer kind, direction, and the two parity-error-response enables. With that context come the local parity check results from each bus and the sampled secondary PERR# input.

The bridge masters the secondary bus on downstream traffic. There, a parity problem reported by the secondary target, or one found by the bridge itself, latches a sticky status flag. Software clears the flag by writing a 1 to it. On the primary bus the bridge reports PERR# in two cases: when it is the target of a downstream write, and when it is the initiator of an upstream read. Errors seen only on the secondary side of a downstream delayed write are also forwarded to the primary PERR#. This lets the original initiator learn that its write was not delivered cleanly. Posted writes never forward a secondary error. The PERR# drive lasts one clock and comes a fixed number of clocks after the data phase. It is presented as an active-low level plus an output enable.

Top module: `perr_report_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `sec_mdpe_flag` is 0, `pri_perr_oe` is 0 and `pri_perr_n` is 1.
- R2: A data phase (`dphase_valid`=1) with `xfer_dir`=0 (downstream, bridge masters the secondary bus) and kind read, posted or delayed sets `sec_mdpe_flag` after that clock edge. The phase must have `sec_per_en`=1 and either `sec_par_err`=1 or `sec_perr_n`=0.
- R3: `sec_mdpe_flag` is never set by upstream phases (`xfer_dir`=1), by phases with `sec_per_en`=0, or by cycles with `dphase_valid`=0.
- R4: `sec_mdpe_flag` holds its value until a write (`sts_wr_en`=1) with `sts_wr_bit`=1 clears it. A write with `sts_wr_bit`=0 leaves it unchanged. A set and a clear in the same cycle leave it set.
- R5: With `pri_per_en`=1, `pri_par_err`=1 fires PERR# when the phase is a downstream posted or delayed write, or an upstream read.
- R6: With `pri_per_en`=1, a downstream delayed write with `sec_perr_n`=0 fires PERR# even without a primary parity error. A downstream posted write with `sec_perr_n`=0 or `sec_par_err`=1 and no primary error does not fire it.
- R7: PERR# does not fire for downstream reads, upstream posted or delayed writes, phases with `pri_per_en`=0, or `xfer_kind`=3 (reserved; it also never sets the status flag).
- R8: A firing phase sampled at clock edge k drives `pri_perr_oe`=1 and `pri_perr_n`=0 for exactly the cycle after edge k+1. At all other times `pri_perr_oe`=0 and `pri_perr_n`=1.
- R9: Kind encoding on `xfer_kind`: 0 read, 1 posted write, 2 delayed write, 3 reserved. On `xfer_dir`: 0 downstream, 1 upstream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dphase_valid | input | 1 | A data phase completes this cycle |
| xfer_kind | input | 2 | 0 read, 1 posted write, 2 delayed write, 3 reserved |
| xfer_dir | input | 1 | 0 downstream, 1 upstream |
| pri_per_en | input | 1 | Primary command register parity-error-response enable |
| sec_per_en | input | 1 | Secondary bridge control parity-error-response enable |
| pri_par_err | input | 1 | Bridge found bad data parity on the primary bus |
| sec_par_err | input | 1 | Bridge found bad data parity on the secondary bus |
| sec_perr_n | input | 1 | Sampled secondary PERR#, active low |
| sts_wr_en | input | 1 | Software write to the status bit |
| sts_wr_bit | input | 1 | Value written; 1 clears the flag |
| sec_mdpe_flag | output | 1 | Sticky secondary master data parity error flag |
| pri_perr_n | output | 1 | Primary PERR# level, active low |
| pri_perr_oe | output | 1 | Primary PERR# output enable |

## Verification
The status flag is due one clock edge after the data phase that sets it, so the bench reads it at the falling edge right after that edge. It reads it again two cycles later to confirm it stayed set. The PERR# pulse is due after the second rising edge from the phase. The bench samples `pri_perr_oe` and `pri_perr_n` at the falling edges after the first, second and third edges, expecting idle, pulse and idle. It spaces each swept case far enough apart that no earlier pulse can overlap the window it is checking.

// File: rtl/perr_pkg.sv
package perr_pkg;

    typedef enum logic [1:0] {
        KIND_READ    = 2'd0,
        KIND_POSTED  = 2'd1,
        KIND_DELAYED = 2'd2,
        KIND_RSVD    = 2'd3
    } xfer_kind_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } xfer_dir_e;

    // Role the bridge plays for one data phase
    typedef struct packed {
        logic sec_master;    // bridge masters the secondary bus
        logic pri_tgt_write; // bridge is target of a write on the primary bus
        logic pri_init_read; // bridge initiates a read on the primary bus
        logic fwd_sec_perr;  // a secondary PERR# is forwarded to the primary
    } bridge_role_t;

    // Per-phase error observations
    typedef struct packed {
        logic pri_par;
        logic sec_par;
        logic sec_perr;
    } phase_err_t;

    function automatic bridge_role_t role_of(input xfer_kind_e kind, input xfer_dir_e dir);
        bridge_role_t r;
        logic known;
        logic is_wr;
        known = (kind != KIND_RSVD);
        is_wr = (kind == KIND_POSTED) || (kind == KIND_DELAYED);
        r.sec_master    = known && (dir == DIR_DOWN);
        r.pri_tgt_write = is_wr && (dir == DIR_DOWN);
        r.pri_init_read = (kind == KIND_READ) && (dir == DIR_UP);
        r.fwd_sec_perr  = (kind == KIND_DELAYED) && (dir == DIR_DOWN);
        return r;
    endfunction

endpackage

// File: rtl/perr_ctx_decode.sv
module perr_ctx_decode
    import perr_pkg::*;
(
    input  logic         phase_ok,
    input  xfer_kind_e   kind,
    input  xfer_dir_e    dir,
    input  logic         pri_en,
    input  logic         sec_en,
    input  phase_err_t   errs,
    output logic         set_flag,
    output logic         fire_perr
);
    bridge_role_t role;
    logic pri_report;
    logic fwd_report;

    always_comb begin
        role       = role_of(kind, dir);
        pri_report = errs.pri_par && (role.pri_tgt_write || role.pri_init_read);
        fwd_report = errs.sec_perr && role.fwd_sec_perr;
        set_flag   = phase_ok && sec_en && role.sec_master
                     && (errs.sec_par || errs.sec_perr);
        fire_perr  = phase_ok && pri_en && (pri_report || fwd_report);
    end
endmodule

// File: rtl/perr_sts_reg.sv
module perr_sts_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag
);
    logic clr_req;
    assign clr_req = wr_en && wr_bit;

    // A hardware set outranks a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
        else if (clr_req)
            flag <= 1'b0;
    end
endmodule

// File: rtl/perr_drive_pipe.sv
module perr_drive_pipe #(
    parameter int LAG = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic drive_oe,
    output logic drive_n
);
    logic [LAG-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= 1'b0;
        else     stage[0] <= fire;
    end

    for (genvar i = 1; i < LAG; i++) begin : g_lag
        always_ff @(posedge clk) begin
            if (rst) stage[i] <= 1'b0;
            else     stage[i] <= stage[i-1];
        end
    end

    assign drive_oe = stage[LAG-1];
    assign drive_n  = ~stage[LAG-1];
endmodule

// File: rtl/perr_report_unit.sv
module perr_report_unit
    import perr_pkg::*;
#(
    parameter int PERR_LAG = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dphase_valid,
    input  logic [1:0] xfer_kind,
    input  logic       xfer_dir,
    input  logic       pri_per_en,
    input  logic       sec_per_en,
    input  logic       pri_par_err,
    input  logic       sec_par_err,
    input  logic       sec_perr_n,
    input  logic       sts_wr_en,
    input  logic       sts_wr_bit,
    output logic       sec_mdpe_flag,
    output logic       pri_perr_n,
    output logic       pri_perr_oe
);
    phase_err_t errs;
    logic       set_flag;
    logic       fire_perr;

    assign errs.pri_par  = pri_par_err;
    assign errs.sec_par  = sec_par_err;
    assign errs.sec_perr = ~sec_perr_n;

    perr_ctx_decode u_dec (
        .phase_ok  (dphase_valid),
        .kind      (xfer_kind_e'(xfer_kind)),
        .dir       (xfer_dir_e'(xfer_dir)),
        .pri_en    (pri_per_en),
        .sec_en    (sec_per_en),
        .errs      (errs),
        .set_flag  (set_flag),
        .fire_perr (fire_perr)
    );

    perr_sts_reg u_sts (
        .clk     (clk),
        .rst     (rst),
        .set_req (set_flag),
        .wr_en   (sts_wr_en),
        .wr_bit  (sts_wr_bit),
        .flag    (sec_mdpe_flag)
    );

    perr_drive_pipe #(.LAG(PERR_LAG)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire_perr),
        .drive_oe (pri_perr_oe),
        .drive_n  (pri_perr_n)
    );
endmodule

// File: rtl/perr_report_chk.sv
module perr_report_chk #(
    parameter int LAG = 2
) (
    input logic clk,
    input logic rst,
    input logic dphase_valid,
    input logic xfer_dir,
    input logic pri_per_en,
    input logic sec_per_en,
    input logic sts_wr_en,
    input logic sts_wr_bit,
    input logic sec_mdpe_flag,
    input logic pri_perr_n,
    input logic pri_perr_oe
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!sec_mdpe_flag && !pri_perr_oe && pri_perr_n));

    assert_set_source_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_mdpe_flag) |-> ($past(dphase_valid) && $past(sec_per_en) && !$past(xfer_dir)));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (sec_mdpe_flag && !(sts_wr_en && sts_wr_bit)) |=> sec_mdpe_flag);

    assert_clear_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(sec_mdpe_flag) |-> ($past(sts_wr_en) && $past(sts_wr_bit)));

    assert_level_pairs_R8: assert property (@(posedge clk) disable iff (rst)
        pri_perr_oe == !pri_perr_n);

    // The two-cycle lookback is only meaningful for the default lag
    if (LAG == 2) begin : g_lag2
        assert_fire_needs_phase_R7: assert property (@(posedge clk) disable iff (rst)
            pri_perr_oe |-> ($past(dphase_valid, 2) && $past(pri_per_en, 2)));
    end
endmodule

bind perr_report_unit perr_report_chk #(.LAG(PERR_LAG)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .dphase_valid  (dphase_valid),
    .xfer_dir      (xfer_dir),
    .pri_per_en    (pri_per_en),
    .sec_per_en    (sec_per_en),
    .sts_wr_en     (sts_wr_en),
    .sts_wr_bit    (sts_wr_bit),
    .sec_mdpe_flag (sec_mdpe_flag),
    .pri_perr_n    (pri_perr_n),
    .pri_perr_oe   (pri_perr_oe)
);

// File: tb/perr_report_unit_tb.sv
module perr_report_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dphase_valid = 1'b0;
    logic [1:0] xfer_kind = 2'd0;
    logic       xfer_dir = 1'b0;
    logic       pri_per_en = 1'b0;
    logic       sec_per_en = 1'b0;
    logic       pri_par_err = 1'b0;
    logic       sec_par_err = 1'b0;
    logic       sec_perr_n = 1'b1;
    logic       sts_wr_en = 1'b0;
    logic       sts_wr_bit = 1'b0;
    logic       sec_mdpe_flag;
    logic       pri_perr_n;
    logic       pri_perr_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    perr_report_unit dut_i (
        .clk(clk), .rst(rst), .dphase_valid(dphase_valid), .xfer_kind(xfer_kind),
        .xfer_dir(xfer_dir), .pri_per_en(pri_per_en), .sec_per_en(sec_per_en),
        .pri_par_err(pri_par_err), .sec_par_err(sec_par_err), .sec_perr_n(sec_perr_n),
        .sts_wr_en(sts_wr_en), .sts_wr_bit(sts_wr_bit), .sec_mdpe_flag(sec_mdpe_flag),
        .pri_perr_n(pri_perr_n), .pri_perr_oe(pri_perr_oe)
    );

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        dphase_valid = 1'b0; sts_wr_en = 1'b0; sts_wr_bit = 1'b0;
        pri_par_err = 1'b0; sec_par_err = 1'b0; sec_perr_n = 1'b1;
    endtask

    // Reference: derived from the requirements, kind 0 rd 1 posted 2 delayed 3 rsvd
    function automatic logic ref_flag(input int k, input int d, input int se, input int e);
        logic sec_err = e[1] || e[2];
        return (se == 1) && (d == 0) && (k != 3) && sec_err;
    endfunction

    function automatic logic ref_perr(input int k, input int d, input int pe, input int e);
        logic pri_case = ((d == 0) && (k == 1 || k == 2)) || ((d == 1) && (k == 0));
        logic fwd_case = (d == 0) && (k == 2) && e[2];
        return (pe == 1) && ((e[0] && pri_case) || fwd_case);
    endfunction

    initial begin
        @(negedge clk);
        check(sec_mdpe_flag, 1'b0, "R1", "flag in reset");
        check(pri_perr_oe, 1'b0, "R1", "oe in reset");
        check(pri_perr_n, 1'b1, "R1", "perr_n in reset");
        step();
        rst = 1'b0;
        step();
        check(sec_mdpe_flag, 1'b0, "R1", "flag after reset");

        // Exhaustive sweep: kind x dir x error sources x enables (R2 R3 R5 R6 R7 R8 R9)
        for (int k = 0; k < 4; k++)
        for (int d = 0; d < 2; d++)
        for (int e = 0; e < 8; e++)
        for (int en = 0; en < 4; en++) begin
            logic ef, ep;
            ef = ref_flag(k, d, en >> 1, e);
            ep = ref_perr(k, d, en & 1, e);
            sts_wr_en = 1'b1; sts_wr_bit = 1'b1;
            step();
            idle_inputs();
            dphase_valid = 1'b1;
            xfer_kind = 2'(k); xfer_dir = d[0];
            pri_per_en = en[0]; sec_per_en = en[1];
            pri_par_err = e[0]; sec_par_err = e[1]; sec_perr_n = ~e[2];
            step();
            idle_inputs();
            check(sec_mdpe_flag, ef, ef ? "R2" : "R3", "flag after phase");
            check(pri_perr_oe, 1'b0, "R8", "oe one edge after phase");
            step();
            check(pri_perr_oe, ep, ep ? "R5/R6" : "R7", "oe two edges after phase");
            check(pri_perr_n, ~ep, "R8", "perr_n two edges after phase");
            step();
            check(pri_perr_oe, 1'b0, "R8", "oe three edges after phase");
            check(sec_mdpe_flag, ef, "R4", "flag sticky");
        end

        // Posted write forwarding negative case, named explicitly (R6)
        pri_per_en = 1'b1; sec_per_en = 1'b1;
        dphase_valid = 1'b1; xfer_kind = 2'd1; xfer_dir = 1'b0; sec_perr_n = 1'b0;
        step(); idle_inputs(); step();
        check(pri_perr_oe, 1'b0, "R6", "posted write does not forward");

        // W1C behaviour (R4)
        sts_wr_en = 1'b1; sts_wr_bit = 1'b1; step(); idle_inputs();
        dphase_valid = 1'b1; xfer_kind = 2'd0; xfer_dir = 1'b0; sec_par_err = 1'b1;
        step(); idle_inputs();
        check(sec_mdpe_flag, 1'b1, "R4", "flag set");
        sts_wr_en = 1'b1; sts_wr_bit = 1'b0; step(); idle_inputs();
        check(sec_mdpe_flag, 1'b1, "R4", "write 0 keeps flag");
        sts_wr_en = 1'b1; sts_wr_bit = 1'b1; step(); idle_inputs();
        check(sec_mdpe_flag, 1'b0, "R4", "write 1 clears flag");
        sts_wr_en = 1'b1; sts_wr_bit = 1'b1;
        dphase_valid = 1'b1; sec_par_err = 1'b1;
        step(); idle_inputs();
        check(sec_mdpe_flag, 1'b1, "R4", "set wins over clear");

        // Errors without a data phase do nothing (R3 R7)
        sts_wr_en = 1'b1; sts_wr_bit = 1'b1; step(); idle_inputs();
        pri_par_err = 1'b1; sec_par_err = 1'b1; sec_perr_n = 1'b0; xfer_kind = 2'd2;
        step(); idle_inputs();
        check(sec_mdpe_flag, 1'b0, "R3", "no phase, no flag");
        step();
        check(pri_perr_oe, 1'b0, "R7", "no phase, no perr");

        // Reset flushes a pending pulse (R1)
        dphase_valid = 1'b1; xfer_kind = 2'd2; xfer_dir = 1'b0; pri_par_err = 1'b1;
        step(); idle_inputs(); rst = 1'b1;
        step(); rst = 1'b0;
        check(pri_perr_oe, 1'b0, "R1", "reset drops pending pulse");
        check(sec_mdpe_flag, 1'b0, "R1", "reset clears flag");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule